// File: doc/BRIEF.md
# Two-Key Bus-Refreshed Watchdog Timer

This block is a watchdog timer that sits on a simple processor bus. The bus has a chip-select, a write strobe, four address bits and an 8-bit data path. Software keeps the watchdog alive with a two-step key sequence. It first writes one fixed byte to key register A, then writes a second fixed byte to key register B. Only when both steps arrive in that order does the timeout counter reload. If the count runs out first, the block drives a reset pulse of fixed length to the rest of the system. The count then starts over.

A static hold-off input can be tied active through a board jumper. While it is active the counter stays at full value, no reset pulse can occur, and any pulse already running ends at once. The key registers are write-only and read back as zero. The timeout and the pulse length are parameters counted in clock cycles.

Top module: `wdog_twokey`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `wd_rst_o` is low, no partial key sequence is pending, and a full timeout period starts.
- R2: A write of 8'h55 to address 4'hC, followed later by a write of 8'hAA to address 4'hD, reloads the counter. `wd_rst_o` then cannot rise until TIMEOUT_CYCLES further clock edges have passed without a new reload.
- R3: A write of 8'hAA to address 4'hD with no correct key-A write pending does not reload the counter.
- R4: Any write to 4'hC with a value other than 8'h55, and any write at all to 4'hD, clears a pending key-A step. After that, the refresh must begin again with key A.
- R5: If no reload occurs, `wd_rst_o` rises at the TIMEOUT_CYCLES-th clock edge after the last reload.
- R6: `wd_rst_o` stays high for exactly PULSE_CYCLES clock cycles. After it falls, a new full timeout period begins.
- R7: While `hold_off` is high, `wd_rst_o` is low and the counter is held full. Once `hold_off` falls, a complete timeout period passes before any reset pulse.
- R8: A read (`bus_cs` high, `bus_we` low) at any address returns 8'h00 on `bus_rdata` and leaves a pending key-A step intact. Writes to other addresses, or any access with `bus_cs` low, leave the state unchanged.
- R9: A completed key sequence that lands in the same cycle in which the timeout would expire wins: no pulse is produced, and the counter reloads.
- R10: A completed key sequence during a reset pulse neither shortens nor extends the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip-select, active high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (always 8'h00) |
| hold_off | input | 1 | Jumper-driven disable, active high |
| wd_rst_o | output | 1 | System reset request |

## Verification
The key-B write that completes a sequence can arrive in the very cycle in which the counter reaches its last count. The bench steers this case from its own reference model: after a key-A write, it waits until the model reports one cycle left, then issues the key-B write. The rule is that the reload wins and no pulse appears. A second collision puts a completed sequence inside a running pulse. Here the pulse length must stay unchanged.

// File: rtl/wdog_twokey.sv
module wdog_twokey #(
  parameter int unsigned TIMEOUT_CYCLES = 1000000,
  parameter int unsigned PULSE_CYCLES   = 16,
  parameter logic [3:0]  KEY_A_ADDR     = 4'hC,
  parameter logic [3:0]  KEY_B_ADDR     = 4'hD,
  parameter logic [7:0]  KEY_A_VAL      = 8'h55,
  parameter logic [7:0]  KEY_B_VAL      = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_cs,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       hold_off,
  output logic       wd_rst_o
);
  localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int PW = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_FULL   = CW'(TIMEOUT_CYCLES - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYCLES - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;

  wire wr      = bus_cs & bus_we;
  wire hit_a   = wr && (bus_addr == KEY_A_ADDR);
  wire hit_b   = wr && (bus_addr == KEY_B_ADDR);
  wire refresh = hit_b && (bus_wdata == KEY_B_VAL) && armed_q;

  assign bus_rdata = '0;

  always_ff @(posedge clk) begin
    if (rst)        armed_q <= 1'b0;
    else if (hit_a) armed_q <= (bus_wdata == KEY_A_VAL);
    else if (hit_b) armed_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_off) begin
      cnt_q    <= CNT_FULL;
      pcnt_q   <= '0;
      wd_rst_o <= 1'b0;
    end else if (wd_rst_o) begin
      if (pcnt_q == '0) begin
        wd_rst_o <= 1'b0;
        cnt_q    <= CNT_FULL;
      end else begin
        pcnt_q <= pcnt_q - 1'b1;
      end
    end else if (refresh) begin
      cnt_q <= CNT_FULL;
    end else if (cnt_q == '0) begin
      wd_rst_o <= 1'b1;
      pcnt_q   <= PULSE_LAST;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (refresh && !hold_off && !wd_rst_o) |=> (cnt_q == CNT_FULL && !wd_rst_o));
  // R4
  seq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((hit_a && bus_wdata != KEY_A_VAL) || hit_b) |=> !armed_q);
  // R5
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst_o) |-> $past(!hold_off && !refresh));
  // R6
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wd_rst_o && !hold_off && pcnt_q != '0) |=> wd_rst_o);
  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    hold_off |=> (!wd_rst_o && cnt_q == CNT_FULL));
endmodule

// File: tb/wdog_twokey_bench.sv
module wdog_twokey_bench;
  localparam int T = 40;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cs = 1'b0, bus_we = 1'b0, hold_off = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic wd_rst_o;

  always #10 clk = ~clk;

  wdog_twokey #(.TIMEOUT_CYCLES(T), .PULSE_CYCLES(P)) u_wdog_twokey (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hold_off(hold_off), .wd_rst_o(wd_rst_o));

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  int m_armed = 0, m_idle = 0, m_left = 0, m_rst = 0, rises = 0;
  bit done = 0;

  // behavioural model: idle cycles since reload, pulse cycles remaining
  always @(posedge clk) begin
    bit wr, fresh;
    cycles++;
    wr = bus_cs && bus_we;
    fresh = wr && bus_addr == 4'hD && bus_wdata == 8'hAA && m_armed == 1;
    if (rst) begin
      m_armed = 0; m_idle = 0; m_left = 0; m_rst = 0;
    end else begin
      if (wr && bus_addr == 4'hC) m_armed = (bus_wdata == 8'h55);
      else if (wr && bus_addr == 4'hD) m_armed = 0;
      if (hold_off) begin
        m_idle = 0; m_left = 0; m_rst = 0;
      end else if (m_rst == 1) begin
        m_left--;
        if (m_left == 0) begin m_rst = 0; m_idle = 0; end
      end else if (fresh) m_idle = 0;
      else if (m_idle == T - 1) begin m_rst = 1; m_left = P; rises++; end
      else m_idle++;
    end
    #5;
    checks++;
    if (wd_rst_o !== m_rst[0]) begin
      failures++;
      $display("FAIL %s wd_rst_o actual=%b expected=%0d t=%0t", cur_req, wd_rst_o, m_rst, $time);
    end
    checks++;
    if (bus_rdata !== 8'h00) begin // R8
      failures++;
      $display("FAIL R8 bus_rdata actual=%h expected=00", bus_rdata);
    end
  end

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic acc(input bit cs, input bit we, input logic [3:0] a, input logic [7:0] d);
    bus_cs = cs; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic expect_cnt(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) if (!done && cycles > 20000) begin
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    finish_run();
  end

  initial begin
    int base;
    idle_n(3);
    rst = 0;
    expect_cnt("R1", int'(wd_rst_o), 0);
    // R2: keep alive over several periods
    cur_req = "R2";
    base = rises;
    for (int k = 0; k < 4; k++) begin
      idle_n(T - 8);
      acc(1, 1, 4'hC, 8'h55); idle_n(2); acc(1, 1, 4'hD, 8'hAA);
    end
    expect_cnt("R2", rises - base, 0);
    // R3: key B alone, then let it expire (R5, R6)
    cur_req = "R3";
    base = rises;
    acc(1, 1, 4'hD, 8'hAA);
    idle_n(T);
    expect_cnt("R3", rises - base, 1);
    cur_req = "R6";
    idle_n(P + 2);
    expect_cnt("R6", int'(wd_rst_o), 0);
    // R4: wrong A, wrong B, then repeated B
    cur_req = "R4";
    base = rises;
    acc(1, 1, 4'hC, 8'h54); acc(1, 1, 4'hD, 8'hAA);
    acc(1, 1, 4'hC, 8'h55); acc(1, 1, 4'hD, 8'hAB); acc(1, 1, 4'hD, 8'hAA);
    acc(1, 1, 4'hC, 8'h55); acc(1, 1, 4'hC, 8'h00); acc(1, 1, 4'hD, 8'hAA);
    idle_n(T);
    expect_cnt("R4", rises - base, 1);
    idle_n(P + 2);
    // R5: exact expiry edge, compared every cycle by the model
    cur_req = "R5";
    idle_n(T + P + 3);
    // R8: reads, foreign writes and deselected writes keep pending A
    cur_req = "R8";
    base = rises;
    idle_n(5);
    acc(1, 1, 4'hC, 8'h55);
    acc(1, 0, 4'hC, 8'h00); acc(1, 0, 4'hD, 8'h00);
    acc(1, 1, 4'h3, 8'h12); acc(0, 1, 4'hC, 8'h00); acc(0, 1, 4'hD, 8'h01);
    acc(1, 1, 4'hD, 8'hAA);
    idle_n(T - 10);
    expect_cnt("R8", rises - base, 0);
    // R9: key B in the expiry cycle
    cur_req = "R9";
    acc(1, 1, 4'hC, 8'h55);
    while (m_idle != T - 1 || m_rst != 0) @(negedge clk);
    base = rises;
    acc(1, 1, 4'hD, 8'hAA);
    idle_n(T - 3);
    expect_cnt("R9", rises - base, 0);
    // R10: refresh inside a pulse
    cur_req = "R10";
    while (m_rst == 0) @(negedge clk);
    acc(1, 1, 4'hC, 8'h55); acc(1, 1, 4'hD, 8'hAA);
    idle_n(P + 2);
    expect_cnt("R10", int'(wd_rst_o), 0);
    // R7: hold-off across an expiry and during a pulse
    cur_req = "R7";
    base = rises;
    hold_off = 1;
    idle_n(3 * T);
    expect_cnt("R7", rises - base, 0);
    hold_off = 0;
    idle_n(T - 2);
    expect_cnt("R7", int'(wd_rst_o), 0);
    while (m_rst == 0) @(negedge clk);
    idle_n(1);
    hold_off = 1;
    idle_n(2);
    expect_cnt("R7", int'(wd_rst_o), 0);
    hold_off = 0;
    idle_n(T + P + 3);
    // R1: reset in mid-sequence
    cur_req = "R1";
    acc(1, 1, 4'hC, 8'h55);
    rst = 1; idle_n(2); rst = 0;
    base = rises;
    acc(1, 1, 4'hD, 8'hAA);
    idle_n(T);
    expect_cnt("R1", rises - base, 1);
    idle_n(P + 2);
    done = 1;
    finish_run();
  end
endmodule